// File: doc/BRIEF.md
# Power-Up Strap Latch Sequencer

This block sequences a set of dual-purpose pads. The pads first act as configuration inputs and later as driven clock outputs. When the supply-good indication rises, the block keeps every shared pad undriven for a fixed settling window counted on the reference clock. During that window the external pull resistor on each pad sets its level.

When the window ends, the block captures the synchronized pad levels once and then enables the pad drivers. The captured bits are cleared only when supply-good falls. Nothing else reaches them, and the sequencer never leaves its driving state on its own.

Three straps are decoded:
- A frequency-select strap chooses between a 48 MHz and a 24 MHz rate for the shared clock output.
- A spread strap turns on a small down-spread of the synthesized clocks.
- An enable strap can hold every clock output of the device in high impedance.

The decoded results go to the clock generation logic elsewhere on the chip.

Top module: `strap_seq_top`

## Requirements
- R1: While `supply_ok` is low, `pad_oe` is 3'b000 and `clk_oe`, `cfg_use_24m` and `cfg_spread_on` are 0, asynchronously.
- R2: From the rise of `supply_ok`, all outputs stay 0 through the first SETTLE_CYCLES+3 rising edges of `ref_clk`, whatever the pad levels do.
- R3: The latched strap vector equals `pad_in` as sampled on rising edge SETTLE_CYCLES+2 after `supply_ok` rises. This is a two-flop synchronizer followed by a capture one cycle after the count ends. Pad levels on every other edge have no effect.
- R4: If bit 2 (enable strap) was latched high, all three `pad_oe` bits and `clk_oe` become 1 right after rising edge SETTLE_CYCLES+4 and stay 1.
- R5: If bit 2 was latched low, `pad_oe` stays 3'b000 and `clk_oe` stays 0 after the window, so every clock output stays in high impedance.
- R6: After the window, `cfg_use_24m` equals latched bit 0. A value of 0 selects 48 MHz and a value of 1 selects 24 MHz.
- R7: After the window, `cfg_spread_on` is the inverse of latched bit 1. A low strap enables the 0.5 % down-spread; a high strap disables it.
- R8: Once driving, the outputs hold their values until `supply_ok` falls, whatever `pad_in` does. A later rise of `supply_ok` repeats the full sequence with fresh straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock (nominally 14.318 MHz) |
| supply_ok | input | 1 | Supply-good indication, active high; low acts as an asynchronous reset |
| pad_in | input | 3 | Pad input levels: bit 0 frequency select, bit 1 spread, bit 2 output enable |
| pad_oe | output | 3 | Per-pad output-driver enable |
| clk_oe | output | 1 | Global enable for all clock outputs |
| cfg_use_24m | output | 1 | 1 selects 24 MHz on the shared output, 0 selects 48 MHz |
| cfg_spread_on | output | 1 | 1 enables down-spread modulation |

## Verification
Power-up runs use the strap patterns 100, 011 and 111. These separate the enable-strap-high case from the all-outputs-off case, and they expose any inversion of the frequency or spread decode. A pulse on the pads that is present only on the capture edge shows whether sampling happens on exactly the right cycle and not one early or one late. Pad toggling after the window shows that nothing but supply loss clears the latch. A supply drop in the middle of the window shows that the count restarts from zero.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned STRAP_PINS = 3;
  localparam int unsigned PIN_FSEL   = 0;
  localparam int unsigned PIN_SPREAD = 1;
  localparam int unsigned PIN_OE     = 2;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_SETTLE  = 2'd1,
    SQ_CAPTURE = 2'd2,
    SQ_DRIVE   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/strap_pad_sync.sv
module strap_pad_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
  parameter int unsigned CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = run_i && (cnt_q == LAST);
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || done_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top #(
  parameter int unsigned SETTLE_CYCLES = 28636,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       ref_clk,
  input  logic       supply_ok,
  input  logic [2:0] pad_in,
  output logic [2:0] pad_oe,
  output logic       clk_oe,
  output logic       cfg_use_24m,
  output logic       cfg_spread_on
);
  import strap_pkg::*;

  logic                  rst_n;
  logic [STRAP_PINS-1:0] pad_s;
  logic [STRAP_PINS-1:0] strap_q;
  logic                  win_done;
  logic                  drive;
  logic                  cap_en;
  seq_state_e            state_q, state_d;

  strap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(ref_clk), .por_n(supply_ok), .rst_n_o(rst_n)
  );

  strap_pad_sync #(.WIDTH(STRAP_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .d_i(pad_in), .q_o(pad_s)
  );

  strap_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(ref_clk), .rst_n(rst_n), .run_i(state_q == SQ_SETTLE), .done_o(win_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE:    state_d = SQ_SETTLE;
      SQ_SETTLE:  if (win_done) state_d = SQ_CAPTURE;
      SQ_CAPTURE: state_d = SQ_DRIVE;
      SQ_DRIVE:   state_d = SQ_DRIVE;
      default:    state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign cap_en = (state_q == SQ_CAPTURE);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)      strap_q <= '0;
    else if (cap_en) strap_q <= pad_s;
  end

  assign drive         = (state_q == SQ_DRIVE);
  assign clk_oe        = drive & strap_q[PIN_OE];
  assign cfg_use_24m   = drive & strap_q[PIN_FSEL];
  assign cfg_spread_on = drive & ~strap_q[PIN_SPREAD];

  for (genvar p = 0; p < STRAP_PINS; p++) begin : g_pad_oe
    assign pad_oe[p] = clk_oe;
  end
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk
  import strap_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input seq_state_e state,
  input logic [2:0] pad_oe,
  input logic       clk_oe,
  input logic       cfg_use_24m,
  input logic       cfg_spread_on
);
  // R2: no pad driven before the sequencer reaches its driving state
  p_quiet_window_r2: assert property (@(posedge clk) disable iff (!por_n)
    (state != SQ_DRIVE) |-> (pad_oe == 3'b000 && !clk_oe && !cfg_use_24m && !cfg_spread_on));

  // R3: capture lasts one cycle and is followed by drive
  p_capture_once_r3: assert property (@(posedge clk) disable iff (!por_n)
    (state == SQ_CAPTURE) |=> (state == SQ_DRIVE));

  // R4: drive is entered only from capture
  p_drive_entry_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(state == SQ_DRIVE) |-> $past(state == SQ_CAPTURE));

  // R8: drive is sticky and its outputs are frozen
  p_drive_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    (state == SQ_DRIVE) |=> (state == SQ_DRIVE));

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!por_n)
    (state == SQ_DRIVE) |=> $stable({pad_oe, clk_oe, cfg_use_24m, cfg_spread_on}));
endmodule

bind strap_seq_top strap_seq_chk chk_i (
  .clk(ref_clk), .por_n(supply_ok), .state(state_q), .pad_oe(pad_oe),
  .clk_oe(clk_oe), .cfg_use_24m(cfg_use_24m), .cfg_spread_on(cfg_spread_on)
);

// File: tb/strap_seq_tb.sv
module strap_seq_top_tb_top;
  localparam int S = 20;

  logic       clk = 1'b0;
  logic       supply_ok = 1'b0;
  logic [2:0] pad_in = 3'b000;
  logic [2:0] pad_oe;
  logic       clk_oe, cfg_use_24m, cfg_spread_on;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // reference model state
  int         edges = 0;
  logic [2:0] lat_m = 3'b000;
  bit         drv_m = 1'b0;

  strap_seq_top #(.SETTLE_CYCLES(S)) dut_i (
    .ref_clk(clk), .supply_ok(supply_ok), .pad_in(pad_in), .pad_oe(pad_oe),
    .clk_oe(clk_oe), .cfg_use_24m(cfg_use_24m), .cfg_spread_on(cfg_spread_on)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update at the edge, comparison 1 ns later
  always begin
    @(posedge clk);
    cycles++;
    if (!supply_ok) begin
      edges = 0;
    end else begin
      edges++;
      if (edges == S + 2) lat_m = pad_in;
    end
    drv_m = supply_ok && (edges >= S + 4);
    #1;
    if (!done) begin
      string t_oe;
      logic  e_oe;
      e_oe = drv_m & lat_m[2];
      t_oe = !supply_ok ? "R1" : (!drv_m ? "R2" : (lat_m[2] ? "R4" : "R5"));
      check(pad_oe == {3{e_oe}}, t_oe, int'(pad_oe), int'({3{e_oe}}));
      check(clk_oe == e_oe, t_oe, int'(clk_oe), int'(e_oe));
      check(cfg_use_24m == (drv_m & lat_m[0]), drv_m ? "R6" : "R2",
            int'(cfg_use_24m), int'(drv_m & lat_m[0]));
      check(cfg_spread_on == (drv_m & ~lat_m[1]), drv_m ? "R7" : "R2",
            int'(cfg_spread_on), int'(drv_m & ~lat_m[1]));
    end
    if (cycles > 200000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    // R1: held in supply-off state
    step(5);
    check(pad_oe == 3'b000 && !clk_oe, "R1", int'(pad_oe), 0);

    // pattern 100: 48 MHz, spread on, outputs on
    pad_in = 3'b100; supply_ok = 1'b1;
    step(S + 6);
    check(clk_oe == 1'b1, "R4", int'(clk_oe), 1);
    check(cfg_use_24m == 1'b0, "R6", int'(cfg_use_24m), 0);
    check(cfg_spread_on == 1'b1, "R7", int'(cfg_spread_on), 1);
    // R8: pads toggle after the window
    for (int i = 0; i < 12; i++) begin
      pad_in = 3'(i * 5 + 3);
      step(1);
    end
    check(clk_oe && !cfg_use_24m && cfg_spread_on, "R8", int'({clk_oe, cfg_use_24m, cfg_spread_on}), 5);

    // pattern 011: enable strap low, everything stays off
    supply_ok = 1'b0; step(1);
    check(pad_oe == 3'b000, "R1", int'(pad_oe), 0);
    pad_in = 3'b011; supply_ok = 1'b1;
    step(S + 10);
    check(pad_oe == 3'b000 && !clk_oe, "R5", int'(pad_oe), 0);
    check(cfg_use_24m == 1'b1 && cfg_spread_on == 1'b0, "R6", int'({cfg_use_24m, cfg_spread_on}), 2);

    // R3: pulse present only on the capture edge S+2
    supply_ok = 1'b0; step(2);
    pad_in = 3'b111; supply_ok = 1'b1;
    step(S + 1);
    pad_in = 3'b101;
    step(1);
    pad_in = 3'b111;
    step(4);
    check(clk_oe && cfg_use_24m && cfg_spread_on, "R3", int'({clk_oe, cfg_use_24m, cfg_spread_on}), 7);

    // R8: supply drop mid-window restarts the count, new straps 110
    supply_ok = 1'b0; step(1);
    pad_in = 3'b110; supply_ok = 1'b1;
    step(S / 2);
    supply_ok = 1'b0; step(1);
    supply_ok = 1'b1;
    step(S + 2);
    check(pad_oe == 3'b000, "R2", int'(pad_oe), 0);
    step(4);
    check(clk_oe && !cfg_use_24m && !cfg_spread_on, "R8", int'({clk_oe, cfg_use_24m, cfg_spread_on}), 4);

    step(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule